// File: doc/BRIEF.md
# Interleaved Two-Dimensional Loop Index Generator

This block issues, one pair per accepted clock, the (row, column) indices of a rectangular iteration space of ROWS by COLS points. The order is not row-major. Rows are handled in bands of FACT rows. Inside a band the walk runs along slanted lines. Each line starts at a head point, and each step adds one to the row and subtracts STEP from the column. STEP is derived at elaboration time from the expansion factor FACT and the compression vector (-1, COMP), as (COMP-1)/FACT.

A line ends when its next point would fall outside the band, below the last row, or to the left of column zero. The walk then starts the next line from a new head, one column further to the right. Once heads pass the right edge they slide down one row and left by STEP. When a new head would lie below the band, the walk moves on to the next band. The hardware uses only adds and compares. A loop-body datapath steps `adv_i` to consume indices.

Top module: `il2d_index_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the generator returns to row 0, column 0 with `valid_o` high and `done_o` low.
- R2: With FACT=3, COMP=4 (STEP=1), the first seven issued pairs are (0,0), (0,1), (1,0), (0,2), (1,1), (2,0), (0,3).
- R3: On an advance from (r,c), the next pair is (r+1, c-STEP) whenever r+1 does not exceed the band's top row and c is at least STEP.
- R4: When a line ends and the current head column h is below COLS-1, the next pair is the head moved to column h+1 in the same head row.
- R5: When a line ends and the head column is COLS-1, the next head is one row lower and at column COLS-STEP. The index continues from there.
- R6: When the next head would lie below the band's top row (the smaller of band base + FACT - 1 and ROWS-1), the next pair is (band base + FACT, 0).
- R7: Over one walk from reset, every pair with row < ROWS and column < COLS is issued exactly once, and no other pair is issued while `valid_o` is high.
- R8: The advance that consumes (ROWS-1, COLS-1) drops `valid_o` and raises `done_o` for exactly one clock. `valid_o` then stays low until reset.
- R9: A clock with `adv_i` low leaves `row_o`, `col_o` and `valid_o` unchanged.
- R10: Asserting `rst` in the middle of a walk restarts the walk at (0,0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| adv_i | input | 1 | Consume the current pair and move to the next |
| row_o | output | RW | Current row index |
| col_o | output | CW | Current column index |
| valid_o | output | 1 | Current pair is a live index |
| done_o | output | 1 | One-clock pulse after the final pair is consumed |

## Verification
The hardest case to reach is a head that has passed the right edge in a partial last band. Here the row clip, the column clip and the band clip all meet. The default sizes are chosen so the last band holds a single row and every band clips at the right edge. A full walk therefore passes through all of these cases. The bench compares each pair with an independent enumeration of lines and tags each expected pair with the rule that produced it. A second walk pauses at regular intervals to check that indices hold while advance is low.

// File: rtl/il2d_index_gen.sv
module il2d_index_gen #(
  parameter int ROWS = 7,
  parameter int COLS = 5,
  parameter int FACT = 3,
  parameter int COMP = 4,
  localparam int STEP = (COMP - 1) / FACT,
  localparam int RW = $clog2(ROWS + FACT + 1),
  localparam int CW = $clog2(COLS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv_i,
  output logic [RW-1:0] row_o,
  output logic [CW-1:0] col_o,
  output logic          valid_o,
  output logic          done_o
);
  localparam logic [RW-1:0] LROW = RW'(ROWS - 1);
  localparam logic [CW-1:0] LCOL = CW'(COLS - 1);
  localparam logic [CW-1:0] KC   = CW'(STEP);
  localparam logic [RW-1:0] SPAN = RW'(FACT - 1);
  localparam logic [RW-1:0] BSTP = RW'(FACT);

  typedef enum logic {S_RUN, S_FIN} st_t;

  st_t           st_q;
  logic [RW-1:0] row_q, hr_q, base_q;
  logic [CW-1:0] col_q, hc_q;
  logic          done_q;

  logic [RW-1:0] top_w, nhr_w, band_hi;
  logic [CW-1:0] nhc_w;
  logic          last_w, slide_w, band_end_w;

  assign band_hi    = base_q + SPAN;
  assign top_w      = (band_hi > LROW) ? LROW : band_hi;
  assign last_w     = (row_q == LROW) && (col_q == LCOL);
  assign slide_w    = (row_q < top_w) && (col_q >= KC);
  assign nhr_w      = (hc_q < LCOL) ? hr_q : hr_q + RW'(1);
  assign nhc_w      = (hc_q < LCOL) ? hc_q + CW'(1) : hc_q + CW'(1) - KC;
  assign band_end_w = nhr_w > top_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_RUN;
      row_q  <= '0;
      col_q  <= '0;
      hr_q   <= '0;
      hc_q   <= '0;
      base_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (adv_i && st_q == S_RUN) begin
        if (last_w) begin
          st_q   <= S_FIN;
          done_q <= 1'b1;
        end else if (slide_w) begin
          row_q <= row_q + RW'(1);
          col_q <= col_q - KC;
        end else if (!band_end_w) begin
          row_q <= nhr_w;
          col_q <= nhc_w;
          hr_q  <= nhr_w;
          hc_q  <= nhc_w;
        end else begin
          base_q <= base_q + BSTP;
          row_q  <= base_q + BSTP;
          hr_q   <= base_q + BSTP;
          col_q  <= '0;
          hc_q   <= '0;
        end
      end
    end
  end

  assign row_o   = row_q;
  assign col_o   = col_q;
  assign valid_o = (st_q == S_RUN);
  assign done_o  = done_q;

  p_range_r7: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (row_o <= LROW && col_o <= LCOL));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> ($stable(row_o) && $stable(col_o) && $stable(valid_o)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_src_r8: assert property (@(posedge clk) disable iff (rst)
    (valid_o && adv_i && row_o == LROW && col_o == LCOL) |=> (done_o && !valid_o));

  p_stay_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !valid_o |=> !valid_o);

  p_head_in_band_r6: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (row_o >= base_q && row_o <= top_w));

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (row_o == '0 && col_o == '0 && valid_o && !done_o));
endmodule

// File: tb/test_il2d_index_gen.sv
module test_il2d_index_gen;
  localparam int M = 7;
  localparam int N = 5;
  localparam int F = 3;
  localparam int G = 4;
  localparam int K = (G - 1) / F;
  localparam int RW = $clog2(M + F + 1);
  localparam int CW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adv = 1'b0;
  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic valid, done;

  always #2 clk = ~clk;

  il2d_index_gen #(.ROWS(M), .COLS(N), .FACT(F), .COMP(G)) i_il2d_index_gen (
    .clk(clk), .rst(rst), .adv_i(adv),
    .row_o(row), .col_o(col), .valid_o(valid), .done_o(done));

  int n_chk = 0;
  int n_fail = 0;
  int eq_r[$];
  int eq_c[$];
  string eq_t[$];
  int seen[M*N];
  int first_r[7] = '{0, 0, 1, 0, 1, 2, 0};
  int first_c[7] = '{0, 1, 0, 2, 1, 0, 3};

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic build();
    eq_r.delete(); eq_c.delete(); eq_t.delete();
    for (int b = 0; b < M; b += F) begin
      int top = (b + F - 1 > M - 1) ? M - 1 : b + F - 1;
      for (int vh = 0; vh <= N - 1 + K * (F - 1); vh++) begin
        bit started = 0;
        for (int r = b; r <= top; r++) begin
          int c = vh - K * (r - b);
          if (c >= 0 && c < N) begin
            eq_r.push_back(r);
            eq_c.push_back(c);
            if (vh == 0 && r == b) eq_t.push_back("R6");
            else if (!started && c == vh) eq_t.push_back("R4");
            else if (!started) eq_t.push_back("R5");
            else eq_t.push_back("R3");
            started = 1;
          end
        end
      end
    end
  endtask

  task automatic step(logic a);
    adv = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    adv = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic walk(int holdmod);
    int idx = 0;
    build();
    for (int i = 0; i < M * N; i++) seen[i] = 0;
    check("R7", "expected count", eq_r.size(), M * N);
    while (eq_r.size() > 0) begin
      string tag = (idx < 7) ? "R2" : eq_t[0];
      int er = (idx < 7) ? first_r[idx] : eq_r[0];
      int ec = (idx < 7) ? first_c[idx] : eq_c[0];
      check(tag, "row", int'(row), er);
      check(tag, "col", int'(col), ec);
      check("R7", "valid", int'(valid), 1);
      if (int'(row) < M && int'(col) < N) seen[int'(row) * N + int'(col)]++;
      void'(eq_r.pop_front()); void'(eq_c.pop_front()); void'(eq_t.pop_front());
      idx++;
      if (holdmod > 0 && idx % holdmod == 0) begin
        int pr = int'(row);
        int pc = int'(col);
        step(1'b0);
        check("R9", "row hold", int'(row), pr);
        check("R9", "col hold", int'(col), pc);
        check("R9", "valid hold", int'(valid), 1);
      end
      step(1'b1);
    end
    check("R8", "valid after last", int'(valid), 0);
    check("R8", "done pulse", int'(done), 1);
    step(1'b1);
    check("R8", "done cleared", int'(done), 0);
    check("R8", "valid stays low", int'(valid), 0);
    step(1'b1);
    check("R8", "valid still low", int'(valid), 0);
    begin
      int bad = 0;
      for (int i = 0; i < M * N; i++) if (seen[i] != 1) bad++;
      check("R7", "pairs not seen once", bad, 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    check("R1", "row", int'(row), 0);
    check("R1", "col", int'(col), 0);
    check("R1", "valid", int'(valid), 1);
    check("R1", "done", int'(done), 0);
    walk(0);
    do_reset();
    for (int i = 0; i < 10; i++) step(1'b1);
    do_reset();
    check("R10", "row", int'(row), 0);
    check("R10", "col", int'(col), 0);
    check("R10", "valid", int'(valid), 1);
    walk(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule